// File: doc/BRIEF.md
# Serial Command Frame Decoder for a UART Register Set

This block sits between a host's four-wire serial port (SPI mode 0: clock idles low, data captured on the rising edge, shifted on the falling edge) and the register side of a UART core. The host sends 16-bit frames, most significant bit first. The two leading bits of each frame pick one of four operations. While the frame shifts in, the block shifts a status and read-data word back out. The operation takes effect only when chip select is released after a complete frame. The block then sends single-cycle strobes and register values to the core.

All pins are brought into the system clock domain through a synchronizer chain, so every register runs on one clock. The receive buffer, interrupt logic, baud generator and transmitter belong to the core. The core reports its state to this block on plain input ports: data waiting, transmit buffer empty, transmitter busy, received word and parity, and the clear-to-send pin.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Frame bits 15:14 pick the operation: 2'b11 writes configuration, 2'b01 reads configuration, 2'b10 writes data and 2'b00 reads data.
- R2: A MOSI bit is taken on each rising SCLK edge, MSB first. MISO changes only after a falling SCLK edge or a chip-select fall, so each outgoing bit is stable across the rising edge that follows it.
- R3: An operation commits only when chip select rises after exactly 16 rising SCLK edges. A frame with fewer or more edges changes no output register and raises no strobe.
- R4: Outgoing bit 15 is the core's data-waiting flag and bit 14 is its transmit-empty flag, both captured when chip select falls. For both data operations, bit 9 is 1 when cts_n_i is low, bit 8 is the received parity bit and bits 7:0 are the received word. A configuration read returns {mask, config} in bits 13:0. A configuration write returns zeros in bits 13:0.
- R5: In a configuration write, bits 13:10 are the interrupt masks. They appear on mask_o after the 16th rising SCLK edge, before chip select rises.
- R6: In a configuration write, bits 9:0 are the line settings. They are staged at commit and reach cfg_o only in a cycle in which tx_busy_i is low.
- R7: A committed configuration write pulses cfg_clear_stb_o for one cycle and leaves rts_n_o unchanged.
- R8: In a data write, bit 9 sets the request-to-send pin (rts_n_o = ~bit 9). Bit 10 set means hold-only: only the pin is updated. Bit 10 clear also pulses tx_load_stb_o and loads tx_word_o with bits 8:0 (bit 8 is the parity bit).
- R9: A committed data read pulses rd_pop_stb_o for one cycle. The core uses it to drop its data-waiting flag and its interrupt.
- R10: miso_oe_o is low whenever csn_i is high.
- R11: After reset, rts_n_o is 1, cfg_o and mask_o are 0 and no strobe is active.
- R12: Strobes last one cycle, never coincide, and at most one follows each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Enable for the MISO pad driver |
| rx_ready_i | input | 1 | Core has received data waiting |
| tx_empty_i | input | 1 | Core transmit buffer empty |
| rx_data_i | input | 8 | Oldest received word |
| rx_parity_i | input | 1 | Parity bit of the oldest received word |
| cts_n_i | input | 1 | Clear-to-send pin level, active low |
| tx_busy_i | input | 1 | Transmitter shifting a character |
| cfg_o | output | 10 | Active line settings |
| mask_o | output | 4 | Active interrupt masks |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| cfg_clear_stb_o | output | 1 | Clear pulse for a configuration write |
| tx_load_stb_o | output | 1 | Load pulse for the transmit buffer |
| tx_word_o | output | 9 | Parity bit and data for the transmitter |
| rd_pop_stb_o | output | 1 | Pulse for a data read |

## Verification
All four opcodes are driven with different core status values. The returned word shows whether the output mux picks the right field set for each operation and captures status at the right moment. Configuration writes are sent while the transmitter is busy and again while it is idle. Mask bits are checked with chip select still low. This separates the immediate, staged and deferred paths. Frames of 10, 15 and 17 bits test the exact-length rule. Data writes with hold-only set and clear show whether the request-to-send update is separate from the buffer load.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and opcode type for the serial command decoder.
// Assumes a fixed 16-bit frame with the opcode in the two leading bits.
package spi_cmd_pkg;
    localparam int FRAME_BITS = 16;
    localparam int OP_BITS    = 2;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int DATA_W     = 8;
    localparam int CFG_W      = 10;
    localparam int MASK_W     = 4;
    localparam int TXW_W      = DATA_W + 1;
    localparam int LOW_W      = FRAME_BITS - OP_BITS;
    // field positions the core and host rely on
    localparam int MASK_LSB   = CFG_W;
    localparam int HOLD_BIT   = 10;
    localparam int RTS_BIT    = 9;
    localparam int CTS_BIT    = 9;

    typedef enum logic [OP_BITS-1:0] {
        OP_RD_DATA = 2'b00,
        OP_RD_CFG  = 2'b01,
        OP_WR_DATA = 2'b10,
        OP_WR_CFG  = 2'b11
    } op_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Synchronizer chain for asynchronous pins.
// Assumes each pin changes far slower than clk; STAGES >= 2.
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // shift the pin levels through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
// Frame assembler: counts rising SCLK edges, shifts in MOSI, counts falling
// edges for the output index, and raises opcode, full and commit strobes.
// Assumes synchronized, edge-detected pins in the clk domain.
module spi_frame_rx
    import spi_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_start_i,
    input  logic                  cs_end_i,
    input  logic                  cs_active_i,
    input  logic                  sclk_rise_i,
    input  logic                  sclk_fall_i,
    input  logic                  mosi_i,
    output logic [FRAME_BITS-1:0] word_o,
    output logic                  op_stb_o,
    output logic                  full_stb_o,
    output logic                  commit_stb_o,
    output logic [CNT_W-1:0]      out_idx_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(OP_BITS - 1);

    logic [CNT_W-1:0]      bit_cnt_q;
    logic [CNT_W-1:0]      out_idx_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  take_bit;

    assign take_bit = cs_active_i && sclk_rise_i;

    // rising-edge counter, saturating one past a full frame
    always_ff @(posedge clk) begin
        if (!rst_n)                              bit_cnt_q <= '0;
        else if (cs_start_i)                     bit_cnt_q <= '0;
        else if (take_bit && bit_cnt_q != CNT_OVER) bit_cnt_q <= bit_cnt_q + 1'b1;
    end

    // falling-edge counter selecting the outgoing bit
    always_ff @(posedge clk) begin
        if (!rst_n)                              out_idx_q <= '0;
        else if (cs_start_i)                     out_idx_q <= '0;
        else if (cs_active_i && sclk_fall_i && out_idx_q != CNT_FULL)
            out_idx_q <= out_idx_q + 1'b1;
    end

    // input shift register, MSB arrives first
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg_q <= '0;
        else if (take_bit) shreg_q <= {shreg_q[FRAME_BITS-2:0], mosi_i};
    end

    // progress strobes toward the command executor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_stb_o     <= 1'b0;
            full_stb_o   <= 1'b0;
            commit_stb_o <= 1'b0;
        end else begin
            op_stb_o     <= take_bit && (bit_cnt_q == CNT_OP);
            full_stb_o   <= take_bit && (bit_cnt_q == CNT_LAST);
            commit_stb_o <= cs_end_i && (bit_cnt_q == CNT_FULL);
        end
    end

    assign word_o    = shreg_q;
    assign out_idx_o = out_idx_q;

    // R3: a commit only follows chip-select release
    assert_commit_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb_o |-> !cs_active_i);
    // R3: the frame counter never moves while deselected
    assert_count_frozen_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_active_i && !cs_start_i) |=> $stable(bit_cnt_q));
endmodule

// File: rtl/spi_cmd_exec.sv
// Command executor: builds the outgoing word, decodes committed frames into
// core strobes, updates masks at frame end and defers line settings until
// the transmitter is idle. Assumes strobes from spi_frame_rx.
module spi_cmd_exec
    import spi_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_start_i,
    input  logic                  op_stb_i,
    input  logic                  full_stb_i,
    input  logic                  commit_stb_i,
    input  logic [FRAME_BITS-1:0] word_i,
    input  logic                  rx_ready_i,
    input  logic                  tx_empty_i,
    input  logic                  cts_n_i,
    input  logic                  rx_parity_i,
    input  logic [DATA_W-1:0]     rx_data_i,
    input  logic                  tx_busy_i,
    output logic [FRAME_BITS-1:0] out_word_o,
    output logic [CFG_W-1:0]      cfg_o,
    output logic [MASK_W-1:0]     mask_o,
    output logic                  rts_n_o,
    output logic                  cfg_clear_stb_o,
    output logic                  tx_load_stb_o,
    output logic [TXW_W-1:0]      tx_word_o,
    output logic                  rd_pop_stb_o
);
    op_e                  op_full;
    op_e                  op_early;
    logic [OP_BITS-1:0]   stat_q;
    logic [LOW_W-1:0]     low_q;
    logic [CFG_W-1:0]     cfg_q;
    logic [CFG_W-1:0]     cfg_rb_q;
    logic [CFG_W-1:0]     pend_q;
    logic                 pend_v_q;
    logic [MASK_W-1:0]    mask_q;
    logic                 rts_n_q;
    logic [TXW_W-1:0]     tx_word_q;
    logic [LOW_W-1:0]     data_fields;

    assign op_full  = op_e'(word_i[FRAME_BITS-1 -: OP_BITS]);
    assign op_early = op_e'(word_i[OP_BITS-1:0]);
    assign data_fields = {{(LOW_W-CTS_BIT-1){1'b0}}, ~cts_n_i, rx_parity_i, rx_data_i};

    // outgoing word: status at frame start, fields once opcode is known
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            low_q  <= '0;
        end else if (cs_start_i) begin
            stat_q <= {rx_ready_i, tx_empty_i};
            low_q  <= '0;
        end else if (op_stb_i) begin
            case (op_early)
                OP_RD_CFG:  low_q <= {mask_q, cfg_rb_q};
                OP_RD_DATA,
                OP_WR_DATA: low_q <= data_fields;
                default:    low_q <= '0;
            endcase
        end
    end

    // interrupt masks take effect as soon as the full frame is in
    always_ff @(posedge clk) begin
        if (!rst_n)                                 mask_q <= '0;
        else if (full_stb_i && op_full == OP_WR_CFG) mask_q <= word_i[MASK_LSB +: MASK_W];
    end

    // line settings: stage on commit, apply when transmitter idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            cfg_rb_q <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (commit_stb_i && op_full == OP_WR_CFG) begin
            pend_q   <= word_i[CFG_W-1:0];
            cfg_rb_q <= word_i[CFG_W-1:0];
            pend_v_q <= 1'b1;
        end else if (pend_v_q && !tx_busy_i) begin
            cfg_q    <= pend_q;
            pend_v_q <= 1'b0;
        end
    end

    // committed frames become one-cycle core strobes and pin updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_clear_stb_o <= 1'b0;
            tx_load_stb_o   <= 1'b0;
            rd_pop_stb_o    <= 1'b0;
            rts_n_q         <= 1'b1;
            tx_word_q       <= '0;
        end else begin
            cfg_clear_stb_o <= 1'b0;
            tx_load_stb_o   <= 1'b0;
            rd_pop_stb_o    <= 1'b0;
            if (commit_stb_i) begin
                case (op_full)
                    OP_WR_CFG:  cfg_clear_stb_o <= 1'b1;
                    OP_RD_DATA: rd_pop_stb_o    <= 1'b1;
                    OP_WR_DATA: begin
                        rts_n_q <= ~word_i[RTS_BIT];
                        if (!word_i[HOLD_BIT]) begin
                            tx_load_stb_o <= 1'b1;
                            tx_word_q     <= word_i[TXW_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign out_word_o = {stat_q, low_q};
    assign cfg_o      = cfg_q;
    assign mask_o     = mask_q;
    assign rts_n_o    = rts_n_q;
    assign tx_word_o  = tx_word_q;

    // R12: strobes never coincide
    assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_clear_stb_o, tx_load_stb_o, rd_pop_stb_o}));
    // R12: every strobe lasts one cycle
    assert_strobe_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clear_stb_o || tx_load_stb_o || rd_pop_stb_o)
        |=> !(cfg_clear_stb_o || tx_load_stb_o || rd_pop_stb_o));
    // R6: line settings move only out of an idle-transmitter cycle
    assert_cfg_waits_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> !$past(tx_busy_i));
    // R5: masks move only right after a full frame
    assert_mask_after_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_o) |-> $past(full_stb_i));
    // R8: request-to-send moves only on a commit
    assert_rts_on_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rts_n_o) |-> $past(commit_stb_i));
    // R8: hold-only frames never load the buffer
    assert_hold_blocks_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_stb_o |-> !$past(word_i[HOLD_BIT]));
endmodule

// File: rtl/spi_cmd_decoder.sv
// Top: synchronizes the serial pins, detects edges, and wires the frame
// assembler and command executor; selects the outgoing MISO bit.
// Assumes SCLK half periods span several clk cycles.
module spi_cmd_decoder
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              rx_ready_i,
    input  logic              tx_empty_i,
    input  logic [7:0]        rx_data_i,
    input  logic              rx_parity_i,
    input  logic              cts_n_i,
    input  logic              tx_busy_i,
    output logic [9:0]        cfg_o,
    output logic [3:0]        mask_o,
    output logic              rts_n_o,
    output logic              cfg_clear_stb_o,
    output logic              tx_load_stb_o,
    output logic [8:0]        tx_word_o,
    output logic              rd_pop_stb_o
);
    localparam logic [CNT_W-1:0] IDX_END = CNT_W'(FRAME_BITS);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(FRAME_BITS - 1);

    logic [2:0]            pins_sync;
    logic                  sclk_s, csn_s, mosi_s;
    logic                  sclk_prev_q, csn_prev_q;
    logic                  sclk_rise, sclk_fall, cs_start, cs_end, cs_active;
    logic [FRAME_BITS-1:0] word;
    logic                  op_stb, full_stb, commit_stb;
    logic [CNT_W-1:0]      out_idx;
    logic [FRAME_BITS-1:0] out_word;
    logic [IDX_W-1:0]      out_sel;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({mosi_i, csn_i, sclk_i}),
        .sync_o(pins_sync)
    );

    assign {mosi_s, csn_s, sclk_s} = pins_sync;

    // previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            csn_prev_q  <= 1'b1;
        end else begin
            sclk_prev_q <= sclk_s;
            csn_prev_q  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign sclk_fall = ~sclk_s & sclk_prev_q;
    assign cs_start  = ~csn_s & csn_prev_q;
    assign cs_end    = csn_s & ~csn_prev_q;
    assign cs_active = ~csn_s;

    spi_frame_rx u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_start_i  (cs_start),
        .cs_end_i    (cs_end),
        .cs_active_i (cs_active),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .mosi_i      (mosi_s),
        .word_o      (word),
        .op_stb_o    (op_stb),
        .full_stb_o  (full_stb),
        .commit_stb_o(commit_stb),
        .out_idx_o   (out_idx)
    );

    spi_cmd_exec u_exec (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_start_i     (cs_start),
        .op_stb_i       (op_stb),
        .full_stb_i     (full_stb),
        .commit_stb_i   (commit_stb),
        .word_i         (word),
        .rx_ready_i     (rx_ready_i),
        .tx_empty_i     (tx_empty_i),
        .cts_n_i        (cts_n_i),
        .rx_parity_i    (rx_parity_i),
        .rx_data_i      (rx_data_i),
        .tx_busy_i      (tx_busy_i),
        .out_word_o     (out_word),
        .cfg_o          (cfg_o),
        .mask_o         (mask_o),
        .rts_n_o        (rts_n_o),
        .cfg_clear_stb_o(cfg_clear_stb_o),
        .tx_load_stb_o  (tx_load_stb_o),
        .tx_word_o      (tx_word_o),
        .rd_pop_stb_o   (rd_pop_stb_o)
    );

    // outgoing bit select, MSB first, zero past the frame
    assign out_sel   = IDX_TOP - out_idx[IDX_W-1:0];
    assign miso_o    = (out_idx < IDX_END) ? out_word[out_sel] : 1'b0;
    assign miso_oe_o = ~csn_i;

    // R2: MISO moves only after a falling SCLK edge or a frame start
    assert_miso_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_o) |-> $past(sclk_fall || cs_start));
endmodule

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic rx_ready = 1'b0, tx_empty = 1'b1, rx_parity = 1'b0, cts_n = 1'b1, tx_busy = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic miso, miso_oe, rts_n, clr_stb, load_stb, pop_stb;
    logic [9:0] cfg;
    logic [3:0] mask;
    logic [8:0] tx_word;

    int checks = 0, failures = 0;
    int n_clr = 0, n_load = 0, n_pop = 0;
    bit finished = 1'b0;
    logic prev_any = 1'b0;

    always #5 clk = ~clk;

    spi_cmd_decoder u_spi_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe), .rx_ready_i(rx_ready),
        .tx_empty_i(tx_empty), .rx_data_i(rx_data), .rx_parity_i(rx_parity),
        .cts_n_i(cts_n), .tx_busy_i(tx_busy), .cfg_o(cfg), .mask_o(mask),
        .rts_n_o(rts_n), .cfg_clear_stb_o(clr_stb), .tx_load_stb_o(load_stb),
        .tx_word_o(tx_word), .rd_pop_stb_o(pop_stb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference comparison of pad enable and strobe shape (R10, R12)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10 oe", {31'b0, miso_oe}, {31'b0, ~csn});
            if (prev_any && (clr_stb || load_stb || pop_stb))
                check("R12 width", 32'd1, 32'd0);
            if ((32'(clr_stb) + 32'(load_stb) + 32'(pop_stb)) > 1)
                check("R12 exclusive", 32'd1, 32'd0);
            n_clr  += int'(clr_stb);
            n_load += int'(load_stb);
            n_pop  += int'(pop_stb);
            prev_any <= clr_stb || load_stb || pop_stb;
        end
    end

    task automatic cs_close();
        csn = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic spi_frame(input logic [15:0] w, input int nbits, input bit keep_open,
                             output logic [15:0] rx);
        rx = '0;
        @(negedge clk) csn = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (HP) @(negedge clk);
            if (i < 16) rx[15-i] = miso;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        if (!keep_open) cs_close();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] rx;
        int c0, l0, p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11 reset state
        check("R11 rts_n", {31'b0, rts_n}, 32'd1);
        check("R11 cfg", {22'b0, cfg}, 32'd0);
        check("R11 mask", {28'b0, mask}, 32'd0);
        check("R11 strobes", {29'b0, clr_stb, load_stb, pop_stb}, 32'd0);
        check("R10 idle oe", {31'b0, miso_oe}, 32'd0);

        // R1 R4 R9 read data: ready, not empty, cts low, parity 1, A5
        rx_ready = 1; tx_empty = 0; cts_n = 0; rx_parity = 1; rx_data = 8'hA5;
        p0 = n_pop; c0 = n_clr; l0 = n_load;
        spi_frame(16'h0000, 16, 0, rx);
        check("R4 R2 read data word", {16'b0, rx}, 32'h83A5);
        check("R9 pop count", n_pop - p0, 1);
        check("R1 no other strobe", (n_clr - c0) + (n_load - l0), 0);

        // R4 second data pattern: cts high, parity 0
        rx_ready = 1; tx_empty = 1; cts_n = 1; rx_parity = 0; rx_data = 8'h5A;
        spi_frame(16'h0000, 16, 0, rx);
        check("R4 read data word 2", {16'b0, rx}, 32'hC05A);

        // R5 R6 R7 write config while transmitter busy
        rx_ready = 0; tx_empty = 1; cts_n = 0; rx_parity = 1; rx_data = 8'hA5;
        tx_busy = 1; c0 = n_clr;
        spi_frame(16'hEAB3, 16, 1, rx);
        check("R5 mask before release", {28'b0, mask}, 32'hA);
        check("R6 cfg before release", {22'b0, cfg}, 32'd0);
        check("R4 write config word", {16'b0, rx}, 32'h4000);
        cs_close();
        check("R7 clear count", n_clr - c0, 1);
        check("R7 rts kept", {31'b0, rts_n}, 32'd1);
        repeat (20) @(negedge clk);
        check("R6 cfg held while busy", {22'b0, cfg}, 32'd0);
        tx_busy = 0;
        repeat (4) @(negedge clk);
        check("R6 cfg applied when idle", {22'b0, cfg}, 32'h2B3);

        // R1 R4 read config
        c0 = n_clr; l0 = n_load; p0 = n_pop;
        spi_frame(16'h4000, 16, 0, rx);
        check("R4 read config word", {16'b0, rx}, 32'h6AB3);
        check("R1 read config no strobe", (n_clr - c0) + (n_load - l0) + (n_pop - p0), 0);

        // R8 write data, load
        l0 = n_load;
        spi_frame(16'h833C, 16, 0, rx);
        check("R4 write data word", {16'b0, rx}, 32'h43A5);
        check("R8 load count", n_load - l0, 1);
        check("R8 tx word", {23'b0, tx_word}, 32'h13C);
        check("R8 rts asserted", {31'b0, rts_n}, 32'd0);

        // R8 hold-only write data
        l0 = n_load;
        spi_frame(16'h85FF, 16, 0, rx);
        check("R8 hold no load", n_load - l0, 0);
        check("R8 hold tx word kept", {23'b0, tx_word}, 32'h13C);
        check("R8 hold rts released", {31'b0, rts_n}, 32'd1);

        // R3 short frames
        c0 = n_clr; l0 = n_load;
        spi_frame(16'hFFFF, 10, 0, rx);
        check("R3 short cfg no clear", n_clr - c0, 0);
        check("R3 short cfg mask kept", {28'b0, mask}, 32'hA);
        spi_frame(16'h8200, 15, 0, rx);
        check("R3 short data rts kept", {31'b0, rts_n}, 32'd1);
        check("R3 short data no load", n_load - l0, 0);
        spi_frame(16'h4000, 16, 0, rx);
        check("R3 config kept after abort", {16'b0, rx}, 32'h6AB3);

        // R3 long frame
        p0 = n_pop;
        spi_frame(16'h0000, 17, 0, rx);
        check("R3 long frame no pop", n_pop - p0, 0);

        // R5 R6 write config with idle transmitter
        spi_frame(16'hD40F, 16, 0, rx);
        check("R5 mask second", {28'b0, mask}, 32'h5);
        check("R6 cfg second", {22'b0, cfg}, 32'h00F);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule